// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Register

This block collects a serial bit stream into an 8-stage shift chain and, on command, copies the whole chain at once into an 8-bit holding register that drives the parallel outputs. Because the chain and the holding register have separate rising-edge clocks, new data can be shifted in while the outputs keep showing the previous word. The outputs change only when the storage clock fires.

An active-low asynchronous clear empties the shift chain. It leaves the holding register alone. An output-disable input releases the eight parallel lines to high impedance. The core carries the outputs as a data bus plus a per-bit drive enable, and a thin top wrapper turns these into tri-state pins. A cascade bit always shows the last shift stage, so several devices can be chained into a longer word.

Top module: `serpar_dbuf`

## Requirements
- R1: The parallel outputs change only on a rising storage-clock edge. Shifting alone never alters them.
- R2: On each rising shift-clock edge, stage 0 (stage A) loads `serIn` and each stage k > 0 loads the former value of stage k-1.
- R3: A falling edge of either clock changes neither the shift chain nor the holding register.
- R4: On a rising storage-clock edge, the holding register takes the whole shift chain. Output bit k then shows stage k.
- R5: While `clearN` is low, every shift stage is held at 0 asynchronously, even when shift-clock edges arrive.
- R6: When `outDisable` is 1, `parEn` is all zeros and `parOut` is high impedance. When it is 0, `parEn` is all ones and `parOut` drives the holding register.
- R7: `cascOut` always equals stage 7 (stage H), whatever the value of `outDisable`.
- R8: When both clocks rise together, the holding register captures the chain as it stood before that shift, so it lags by one pulse.
- R9: `clearN` has no effect on the holding register. It keeps its value until the next storage-clock edge.
- R10: With two devices chained (`cascOut` of the first feeding `serIn` of the second), 16 shifts and one store present a 16-bit word. The first bit shifted in lands in stage 7 of the second device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serIn | input | 1 | Serial data into stage 0 |
| shiftClk | input | 1 | Rising-edge clock of the shift chain |
| storeClk | input | 1 | Rising-edge clock of the holding register |
| clearN | input | 1 | Asynchronous active-low clear of the shift chain |
| outDisable | input | 1 | 1 releases the parallel outputs to high impedance |
| parOut | output | 8 | Tri-state parallel outputs; bit k shows held stage k |
| parEn | output | 8 | Per-bit drive enable of `parOut` |
| cascOut | output | 1 | Last shift stage, for chaining |

## Verification
The bench samples the outputs after every shift edge and again after its falling edge. A design whose outputs follow the chain directly, or that acts on falling edges, shows a changed word before any store. A clear is applied while a stored word is on the outputs and while shift edges keep arriving. A clear that also wipes the holding register, or that loses to the shift clock, leaves a wrong word or a set cascade bit. Both clocks are pulsed together, which catches a holding register that takes the post-shift value. A 16-bit word is sent through two chained devices, which catches reversed stage order or a cascade tap on the wrong stage.

// File: rtl/serpar_dbuf_pkg.sv
package serpar_dbuf_pkg;

  localparam int unsigned DEFAULT_STAGES = 8;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic chainClearN;  // active-low asynchronous clear of the shift chain
    logic busDrive;     // 1: parallel bus is driven
  } ctrl_strobe_t;

endpackage

// File: rtl/serpar_dbuf_ctrl.sv
module serpar_dbuf_ctrl
  import serpar_dbuf_pkg::*;
(
  input  logic         clearN,
  input  logic         outDisable,
  output ctrl_strobe_t strobes
);

  always_comb begin
    strobes.chainClearN = clearN;
    strobes.busDrive    = ~outDisable;
  end

endmodule

// File: rtl/serpar_dbuf_datapath.sv
module serpar_dbuf_datapath
  import serpar_dbuf_pkg::*;
#(
  parameter int unsigned STAGES = DEFAULT_STAGES
) (
  input  logic              shiftClk,
  input  logic              storeClk,
  input  logic              serIn,
  input  ctrl_strobe_t      strobes,
  output logic [STAGES-1:0] holdBus,
  output logic [STAGES-1:0] busEn,
  output logic              cascOut
);

  localparam int unsigned LAST = STAGES - 1;

  logic              chainClrN;
  logic [STAGES-1:0] stageIn;
  logic [STAGES-1:0] chainReg;
  logic [STAGES-1:0] holdReg;

  assign chainClrN = strobes.chainClearN;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stageIn[s] = serIn;
    end else begin : g_link
      assign stageIn[s] = chainReg[s-1];
    end
  end

  always_ff @(posedge shiftClk or negedge chainClrN) begin
    if (!chainClrN) chainReg <= '0;
    else            chainReg <= stageIn;
  end

  always_ff @(posedge storeClk) begin
    holdReg <= chainReg;
  end

  assign holdBus = holdReg;
  assign busEn   = {STAGES{strobes.busDrive}};
  assign cascOut = chainReg[LAST];

  // Counts shift edges since the last clear (saturates at 2), used to qualify checks
  logic [1:0] shiftRun;
  always_ff @(posedge shiftClk or negedge chainClrN) begin
    if (!chainClrN)             shiftRun <= 2'd0;
    else if (shiftRun != 2'd2)  shiftRun <= shiftRun + 2'd1;
  end

  // R2
  shift_chain_chk: assert property (@(posedge shiftClk) disable iff (!chainClrN)
    (shiftRun == 2'd2) |-> (chainReg == {$past(chainReg[LAST-1:0]), $past(serIn)}));

  // R7
  cascade_tap_chk: assert property (@(posedge shiftClk) disable iff (!chainClrN)
    (shiftRun == 2'd2) |-> (cascOut == $past(chainReg[LAST-1])));

  // R4 / R8
  hold_load_chk: assert property (@(posedge storeClk) disable iff (!chainClrN)
    1'b1 |=> (holdBus == $past(chainReg)));

endmodule

// File: rtl/serpar_dbuf.sv
module serpar_dbuf
  import serpar_dbuf_pkg::*;
#(
  parameter int unsigned STAGES = DEFAULT_STAGES
) (
  input  logic              serIn,
  input  logic              shiftClk,
  input  logic              storeClk,
  input  logic              clearN,
  input  logic              outDisable,
  output logic [STAGES-1:0] parOut,
  output logic [STAGES-1:0] parEn,
  output logic              cascOut
);

  ctrl_strobe_t      strobes;
  logic [STAGES-1:0] holdBus;
  logic [STAGES-1:0] busEn;

  serpar_dbuf_ctrl u_ctrl (
    .clearN     (clearN),
    .outDisable (outDisable),
    .strobes    (strobes)
  );

  serpar_dbuf_datapath #(.STAGES(STAGES)) u_dp (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .serIn    (serIn),
    .strobes  (strobes),
    .holdBus  (holdBus),
    .busEn    (busEn),
    .cascOut  (cascOut)
  );

  for (genvar b = 0; b < STAGES; b++) begin : g_pin
    assign parOut[b] = busEn[b] ? holdBus[b] : 1'bz;
  end

  assign parEn = busEn;

  // R6
  drive_enable_chk: assert property (@(posedge shiftClk) disable iff (!clearN)
    parEn == {STAGES{~outDisable}});

endmodule

// File: tb/serpar_dbuf_test.sv
module serpar_dbuf_test;

  typedef struct {
    string       tag;
    logic [15:0] par;
    logic        en;
    logic [1:0]  casc;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic serIn = 1'b0, shiftClk = 1'b0, storeClk = 1'b0;
  logic clearN = 1'b0, outDisable = 1'b1;
  logic [7:0] parLo, parHi, enLo, enHi;
  logic cascLo, cascHi;

  serpar_dbuf uut (
    .serIn(serIn), .shiftClk(shiftClk), .storeClk(storeClk), .clearN(clearN),
    .outDisable(outDisable), .parOut(parLo), .parEn(enLo), .cascOut(cascLo));

  serpar_dbuf uutTail (
    .serIn(cascLo), .shiftClk(shiftClk), .storeClk(storeClk), .clearN(clearN),
    .outDisable(outDisable), .parOut(parHi), .parEn(enHi), .cascOut(cascHi));

  int checks = 0;
  int errors = 0;
  logic [15:0] chainM = '0;  // bits 0..7 first device, 8..15 second
  logic [15:0] holdM  = '0;
  exp_t scoreQ[$];
  event checkEv;

  task automatic expectNow(input string tag);
    exp_t e;
    e.tag = tag; e.par = holdM; e.en = ~outDisable; e.casc = {chainM[15], chainM[7]};
    scoreQ.push_back(e);
    -> checkEv;
    #1;
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(checkEv);
      while (scoreQ.size() > 0) begin
        exp_t e;
        e = scoreQ.pop_front();
        checks++;
        if ({enHi, enLo} != {16{e.en}}) begin
          errors++;
          $display("FAIL %s (R6 enable): got %h expected %h", e.tag, {enHi, enLo}, {16{e.en}});
        end
        if (e.en) begin
          checks++;
          if ({parHi, parLo} != e.par) begin
            errors++;
            $display("FAIL %s (parallel): got %h expected %h", e.tag, {parHi, parLo}, e.par);
          end
        end
        checks++;
        if ({cascHi, cascLo} != e.casc) begin
          errors++;
          $display("FAIL %s (R7 cascade): got %b expected %b", e.tag, {cascHi, cascLo}, e.casc);
        end
      end
    end
  end

  task automatic shiftBit(input logic b, input string tag);
    serIn = b;
    #1 shiftClk = 1'b1;
    if (clearN) chainM = {chainM[14:0], b};
    #1 expectNow(tag);
    shiftClk = 1'b0;
    #1 expectNow({"R3 after shift fall / ", tag});
  endtask

  task automatic storePulse(input string tag);
    #1 storeClk = 1'b1;
    holdM = chainM;
    #1 expectNow(tag);
    storeClk = 1'b0;
    #1 expectNow("R3 after store fall");
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0]  byteA;
    logic [15:0] word;
    #3 expectNow("R5 reset state");
    clearN = 1'b1;
    #2 storePulse("R4 R9 store after clear");
    outDisable = 1'b0;
    #1 expectNow("R6 enabled after clear");

    // R2 R1: shift 0xA5, most significant bit first; outputs must not move
    byteA = 8'hA5;
    for (int i = 7; i >= 0; i--) shiftBit(byteA[i], "R2 R1 shifting byte");
    expectNow("R1 outputs held before store");
    storePulse("R4 byte stored");

    // R6 R7: disable outputs, cascade keeps working
    outDisable = 1'b1;
    #1 expectNow("R6 disabled");
    shiftBit(1'b0, "R7 cascade while disabled");
    outDisable = 1'b0;
    #1 expectNow("R6 re-enabled, word unchanged");

    // R5 R9: clear mid-stream, stored word survives
    shiftBit(1'b1, "R2 before clear");
    clearN = 1'b0;
    chainM = '0;
    #1 expectNow("R5 R9 clear keeps holding register");
    shiftBit(1'b1, "R5 clear overrides shift clock");
    clearN = 1'b1;
    #1 storePulse("R5 cleared chain stored");

    // R8: tied clocks
    word = 16'h3C5A;
    for (int i = 15; i >= 0; i--) shiftBit(word[i], "R2 load before tied pulse");
    serIn = 1'b1;
    #1 begin shiftClk = 1'b1; storeClk = 1'b1; end
    holdM = chainM;
    chainM = {chainM[14:0], 1'b1};
    #1 expectNow("R8 tied clocks: store lags shift");
    shiftClk = 1'b0; storeClk = 1'b0;
    #1 storePulse("R8 follow-up store");

    // R10: 16-bit word through two chained devices
    word = 16'hB7E1;
    for (int i = 15; i >= 0; i--) shiftBit(word[i], "R10 chain shifting");
    storePulse("R10 chained word");
    checks++;
    if ({parHi, parLo} != word) begin
      errors++;
      $display("FAIL R10 direct word: got %h expected %h", {parHi, parLo}, word);
    end

    #4 finishRun();
  end

endmodule